// File: doc/BRIEF.md
# Extended Integer ALU with Shared Barrel Shifter

This block is the purely combinational arithmetic and logic stage of a simple integer datapath. It takes two 32-bit register operands, a 5-bit shift amount taken from the instruction word, and a 3-bit operation selector. It returns a 32-bit result together with a flag that is high whenever that result is all zeros.

The block supports addition, subtraction, signed set-on-less-than, arithmetic shift right, and a bit-set operation. Addition and subtraction run on one adder; only the operation selector tells them apart. One logarithmic barrel shifter does both kinds of shifting. For the arithmetic shift it moves operand B right by the instruction field. For bit-set it moves a constant 1 left by the low five bits of operand A, and the result is ORed into operand B. An input multiplexer chooses the shift amount. The result depends only on the present inputs and is valid in the same cycle. No state is held.

Top module: `alu_ext`

## Requirements
- R1: With op_sel = 3'b000, result equals opnd_a + opnd_b modulo 2^32.
- R2: With op_sel = 3'b001, result equals opnd_a - opnd_b modulo 2^32.
- R3: With op_sel = 3'b010, result is 32'd1 when opnd_a is less than opnd_b as signed two's-complement numbers, and 32'd0 otherwise. Equal operands give 0.
- R4: With op_sel = 3'b011, result is opnd_b shifted right by shamt_imm, with bit 31 of opnd_b copied into every vacated upper position.
- R5: For op_sel = 3'b011 the shift amount comes only from shamt_imm. The value of opnd_a has no effect on the result.
- R6: With op_sel = 3'b100, result equals opnd_b OR (32'd1 shifted left by opnd_a[4:0]). Bits 31..5 of opnd_a have no effect.
- R7: shamt_imm has no effect on any operation other than op_sel = 3'b011.
- R8: The codes 3'b101, 3'b110 and 3'b111 produce a result of 0.
- R9: is_zero is 1 exactly when result equals 32'd0.
- R10: Shift amounts 0 and 31 are handled exactly. An arithmetic shift by 0 returns opnd_b unchanged. A bit-set index of 31 sets bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First register operand; its low 5 bits give the bit-set index |
| opnd_b | input | 32 | Second register operand; the value that is shifted or has a bit set |
| shamt_imm | input | 5 | Shift amount taken from the instruction word |
| op_sel | input | 3 | Operation code (000 add, 001 sub, 010 slt, 011 sra, 100 bset) |
| result | output | 32 | Operation result |
| is_zero | output | 1 | High when result is zero |

## Verification
The bound checker applies, at every input change, several relations between the ports:
- is_zero agrees with the result.
- Set-on-less-than returns only 0 or 1.
- An add or subtract result, once B is added back or taken away, gives back operand A.
- An arithmetic shift keeps the sign of B.
- Bit-set leaves every 1 of B in place and sets the indexed bit.
- The unused codes return zero.

Some properties need pairs of stimuli, or exact reference values, so only the bench scenarios can show them:
- opnd_a and the upper index bits are ignored.
- shamt_imm is ignored outside the shift.
- Results are exact at shift amounts 0 and 31.
- Signed comparison is correct across the sign boundary.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

    localparam int DATA_W  = 32;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SLT  = 3'b010,
        OP_SRA  = 3'b011,
        OP_BSET = 3'b100
    } alu_op_e;

endpackage

// File: rtl/alu_amt_sel.sv
// Chooses where the shifter takes its amount from: the instruction field
// for shifts, the low bits of operand A for bit-set.
module alu_amt_sel #(
    parameter int AMT_W = 5
) (
    input  logic [AMT_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  logic             use_reg,
    output logic [AMT_W-1:0] amt
);
    always_comb begin
        amt = use_reg ? reg_amt : imm_amt;
    end
endmodule

// File: rtl/alu_barrel.sv
// Logarithmic barrel shifter: left with zero fill, or right with sign fill.
module alu_barrel #(
    parameter int W     = 32,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  logic             go_left,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stg [0:AMT_W];
    logic         fill;

    assign fill   = din[W-1] & ~go_left;
    assign stg[0] = din;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int SH = 1 << i;
        logic [W-1:0] moved;
        always_comb begin
            if (go_left) begin
                moved = {stg[i][W-1-SH:0], {SH{1'b0}}};
            end else begin
                moved = {{SH{fill}}, stg[i][W-1:SH]};
            end
        end
        assign stg[i+1] = amt[i] ? moved : stg[i];
    end

    assign dout = stg[AMT_W];
endmodule

// File: rtl/alu_addsub.sv
// Shared adder for add and subtract; also derives the signed less-than bit.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         lt_signed
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        // Differing signs decide directly; same signs cannot overflow.
        if (a[W-1] != b[W-1]) begin
            lt_signed = a[W-1];
        end else begin
            lt_signed = sum[W-1];
        end
    end
endmodule

// File: rtl/alu_ext.sv
module alu_ext
    import alu_ext_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [AMT_W-1:0] shamt_imm,
    input  logic [OP_W-1:0]  op_sel,
    output logic [W-1:0]     result,
    output logic             is_zero
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         zero;
    } alu_out_t;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    alu_op_e      op;
    logic         is_bset;
    logic         is_sub;
    logic [AMT_W-1:0] amt;
    logic [W-1:0] sh_in;
    logic [W-1:0] sh_out;
    logic [W-1:0] sum;
    logic         lt;
    alu_out_t     out_d;

    assign op      = alu_op_e'(op_sel);
    assign is_bset = (op == OP_BSET);
    assign is_sub  = (op == OP_SUB) || (op == OP_SLT);
    assign sh_in   = is_bset ? ONE : opnd_b;

    alu_amt_sel #(.AMT_W(AMT_W)) u_amt (
        .imm_amt (shamt_imm),
        .reg_amt (opnd_a[AMT_W-1:0]),
        .use_reg (is_bset),
        .amt     (amt)
    );

    alu_barrel #(.W(W), .AMT_W(AMT_W)) u_shift (
        .din     (sh_in),
        .amt     (amt),
        .go_left (is_bset),
        .dout    (sh_out)
    );

    alu_addsub #(.W(W)) u_arith (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (is_sub),
        .sum       (sum),
        .lt_signed (lt)
    );

    always_comb begin
        out_d = '0;
        unique case (op)
            OP_ADD, OP_SUB: out_d.res = sum;
            OP_SLT:         out_d.res = {{(W-1){1'b0}}, lt};
            OP_SRA:         out_d.res = sh_out;
            OP_BSET:        out_d.res = opnd_b | sh_out;
            default:        out_d.res = '0;
        endcase
        out_d.zero = (out_d.res == '0);
    end

    assign result  = out_d.res;
    assign is_zero = out_d.zero;
endmodule

// File: rtl/alu_ext_chk.sv
module alu_ext_chk #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input logic [W-1:0]     opnd_a,
    input logic [W-1:0]     opnd_b,
    input logic [AMT_W-1:0] shamt_imm,
    input logic [2:0]       op_sel,
    input logic [W-1:0]     result,
    input logic             is_zero
);
    logic [W-1:0] amt_unused;
    assign amt_unused = {{(W-AMT_W){1'b0}}, shamt_imm};

    always_comb begin
        if (amt_unused <= W) begin
            AST_ZERO_FLAG: assert (is_zero == (result == '0)); // R9
            if (op_sel == 3'b000) begin
                AST_ADD_INV: assert (result - opnd_b == opnd_a); // R1
            end
            if (op_sel == 3'b001) begin
                AST_SUB_INV: assert (result + opnd_b == opnd_a); // R2
            end
            if (op_sel == 3'b010) begin
                AST_SLT_BOOL: assert (result[W-1:1] == '0); // R3
            end
            if (op_sel == 3'b011) begin
                AST_SRA_SIGN: assert (result[W-1] == opnd_b[W-1]); // R4
            end
            if (op_sel == 3'b100) begin
                AST_BSET_KEEP: assert (((result & opnd_b) == opnd_b)
                                       && result[opnd_a[AMT_W-1:0]]); // R6
            end
            if (op_sel > 3'b100) begin
                AST_UNUSED_ZERO: assert (result == '0); // R8
            end
        end
    end
endmodule

bind alu_ext alu_ext_chk #(.W(W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/sim_alu_ext.sv
module sim_alu_ext;
    logic        clk = 1'b0;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  shamt_imm;
    logic [2:0]  op_sel;
    logic [31:0] result;
    logic        is_zero;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;  // 125 MHz

    alu_ext u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt_imm(shamt_imm),
        .op_sel(op_sel), .result(result), .is_zero(is_zero)
    );

    function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b,
                                            input logic [4:0] sh, input logic [2:0] op);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: return $unsigned($signed(b) >>> sh);
            3'd4: return b | (32'd1 << a[4:0]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic [2:0] op);
        @(negedge clk);
        opnd_a = a; opnd_b = b; shamt_imm = sh; op_sel = op;
        @(posedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] exp_r);
        n_tests++;
        if (result !== exp_r || is_zero !== (exp_r == 32'd0)) begin
            n_fail++;
            $display("FAIL %s: result=%h zero=%0b expected result=%h zero=%0b",
                     tag, result, is_zero, exp_r, exp_r == 32'd0);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic [2:0] op);
        apply(a, b, sh, op);
        check(tag, ref_alu(a, b, sh, op));
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not end, actual=%0d cycles expected<100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        void'($urandom(32'd20240611));
        // initial state, all-zero inputs: add gives 0, R9
        run("R9_idle", 32'd0, 32'd0, 5'd0, 3'd0);
        run("R1_wrap", 32'hFFFF_FFFF, 32'd2, 5'd7, 3'd0);
        run("R2_to_zero", 32'h1234_5678, 32'h1234_5678, 5'd0, 3'd1);
        run("R2_borrow", 32'd0, 32'd1, 5'd0, 3'd1);
        run("R3_neg_lt_pos", 32'hFFFF_FFFF, 32'd1, 5'd0, 3'd2);
        run("R3_pos_not_lt_neg", 32'd1, 32'hFFFF_FFFF, 5'd0, 3'd2);
        run("R3_equal", 32'h8000_0000, 32'h8000_0000, 5'd0, 3'd2);
        run("R3_extremes", 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 3'd2);
        run("R4_neg", 32'hF000_00F0, 32'hF000_00F0, 5'd4, 3'd3);
        run("R4_pos", 32'd0, 32'h7000_0000, 5'd8, 3'd3);
        run("R10_sra31", 32'd0, 32'h8000_0000, 5'd31, 3'd3);
        run("R10_sra0", 32'd0, 32'hA5A5_0001, 5'd0, 3'd3);
        // R5: opnd_a changes, sra result must stay put
        apply(32'd0, 32'h8765_4321, 5'd5, 3'd3);
        keep = result;
        check("R5_a0", 32'hFC3B_2A19);
        apply(32'hFFFF_FFFF, 32'h8765_4321, 5'd5, 3'd3);
        check("R5_a_all_ones", keep);
        run("R6_bset3", 32'd3, 32'h0000_0100, 5'd0, 3'd4);
        run("R6_upper_a_ignored", 32'hFFFF_FFE2, 32'd0, 5'd0, 3'd4);
        run("R6_bit_already_set", 32'd8, 32'h0000_0100, 5'd0, 3'd4);
        run("R10_bset31", 32'd31, 32'd0, 5'd0, 3'd4);
        // R7: shamt_imm changes on bset and add, result unchanged
        apply(32'd9, 32'h10, 5'd0, 3'd4);
        check("R7_bset_sh0", 32'h0000_0210);
        apply(32'd9, 32'h10, 5'd17, 3'd4);
        check("R7_bset_sh17", 32'h0000_0210);
        apply(32'd5, 32'd6, 5'd31, 3'd0);
        check("R7_add_sh31", 32'd11);
        run("R8_code5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 3'd5);
        run("R8_code6", 32'h1, 32'h2, 5'd3, 3'd6);
        run("R8_code7", 32'h8000_0000, 32'h1, 5'd31, 3'd7);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            logic [2:0]  ro;
            ra = $urandom;
            rb = $urandom;
            ro = 3'($urandom % 8);
            if (i % 5 == 0) rb = ra;
            case (ro)
                3'd0: run("R1_rand", ra, rb, 5'($urandom), ro);
                3'd1: run("R2_rand", ra, rb, 5'($urandom), ro);
                3'd2: run("R3_rand", ra, rb, 5'($urandom), ro);
                3'd3: run("R4_rand", ra, rb, 5'($urandom), ro);
                3'd4: run("R6_rand", ra, rb, 5'($urandom), ro);
                default: run("R8_rand", ra, rb, 5'($urandom), ro);
            endcase
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule